// File: doc/BRIEF.md
# Atomic In-Flight Completion Tracker

This block keeps count of the atomic operations that one cache line has sent to memory while the line waits in its atomic-pending state. It decides when the line's tracking entry can be released. Each atomic sent downstream raises an outstanding count, and each response lowers it. When a response brings the count to zero, the block queues a completion trigger. A second count, equal to the number of triggers still queued, covers one race: a new atomic can arrive after a trigger has been queued but before that trigger is consumed.

The consumer pops triggers from the internal queue. For each pop the block decides between two results. It either releases the entry (done, with free and wakeup pulses, and the line leaves the pending state), or it only retires the trigger (not done). An allocation pulse starts a fresh tracking entry. Misuse raises a sticky error flag: an atomic that asks to bypass the cache, a response with nothing outstanding, a counter overflow, a pop from an empty queue, or a push into a full queue.

Top module: `atomic_drain_tracker`

## Requirements
- R1: After reset all outputs are low, the outstanding count is zero and the trigger queue is empty.
- R2: A clock edge with `issue_i` high (and `issue_bypass_i` low) adds one to the outstanding count, and one with `resp_i` high removes one. When a response brings the count from one to zero with no issue in the same cycle, a trigger is pushed. It appears on `trig_valid_o` and `trig_id_o` after that edge, one cycle later. Trigger ids start at 0 after reset or allocation and increase by one, modulo 2^ID_W, for each accepted push.
- R3: The trigger queue is first-in first-out; `trig_valid_o` is high exactly while it holds at least one trigger, and `trig_id_o` shows the oldest one.
- R4: A pop of a non-empty queue yields, on the next cycle, `done_o` if the outstanding count after that edge's updates is zero, the popped trigger is the only one queued, and no trigger is pushed on that edge; otherwise it yields `notdone_o`. Exactly one of the two pulses for one cycle.
- R5: `free_o` and `wake_o` pulse together with `done_o`, and `busy_o` falls on the same edge.
- R6: `alloc_i` empties the queue, zeroes the outstanding count and the id sequence, and raises `busy_o`; every other input is ignored on that edge.
- R7: An issue with `issue_bypass_i` high is not counted and sets the error flag.
- R8: `err_o` becomes high after an edge with a response while nothing is outstanding, an issue at the maximum count (2^OUT_W-1) without a response, a pop of an empty queue, or a push into a full queue (DEPTH entries) without a pop. In each case the offending event is dropped. Only reset clears the flag.
- R9: An issue and a response on the same edge leave the outstanding count unchanged and push no trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Tracking entry allocated (start of pending state) |
| issue_i | input | 1 | An atomic was forwarded to memory |
| issue_bypass_i | input | 1 | The issued atomic carries the cache-bypass flag |
| resp_i | input | 1 | An atomic response returned from memory |
| trig_pop_i | input | 1 | Consumer takes the oldest completion trigger |
| trig_valid_o | output | 1 | Trigger queue holds at least one trigger |
| trig_id_o | output | ID_W | Sequence id of the oldest trigger |
| done_o | output | 1 | Last pop released the entry |
| notdone_o | output | 1 | Last pop only retired a trigger |
| free_o | output | 1 | Free the tracking entry |
| wake_o | output | 1 | Wake requests waiting on the line |
| busy_o | output | 1 | Line is in the atomic-pending state |
| err_o | output | 1 | Sticky misuse flag |

## Verification
Every result is registered. A trigger, a done or not-done decision, the busy change and the error flag all appear one cycle after the edge that causes them. The bench drives inputs on the falling edge and advances its behavioural model over the following rising edge. It compares every output with the model at the next falling edge, which is exactly one cycle after the stimulus. Each scenario also adds checks tied to a requirement at those same falling edges. The scenarios cover the race, same-cycle issue-and-pop, id wrap, queue fill and counter overflow.

// File: rtl/atq_pkg.sv
package atq_pkg;
   typedef enum logic [1:0] {
      DEC_NONE = 2'd0,
      DEC_DONE = 2'd1,
      DEC_KEEP = 2'd2
   } dec_e;

   function automatic int unsigned occ_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/atq_out_counter.sv
module atq_out_counter #(
   parameter int unsigned OUT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec_req,
   output logic drained,
   output logic zero_next,
   output logic err_under,
   output logic err_over
);
   localparam logic [OUT_W-1:0] CNT_MAX = '1;
   localparam logic [OUT_W-1:0] CNT_ONE = OUT_W'(1);

   logic [OUT_W-1:0] cnt_q, cnt_d;
   logic             dec_ok, inc_ok;

   always_comb begin
      dec_ok    = dec_req && (cnt_q != '0);
      err_under = dec_req && (cnt_q == '0);
      err_over  = inc && !dec_ok && (cnt_q == CNT_MAX);
      inc_ok    = inc && !err_over;
      drained   = dec_ok && !inc && (cnt_q == CNT_ONE);
      cnt_d     = cnt_q;
      if (inc_ok && !dec_ok)
         cnt_d = cnt_q + CNT_ONE;
      else if (dec_ok && !inc_ok)
         cnt_d = cnt_q - CNT_ONE;
      if (clr)
         cnt_d = '0;
      zero_next = (cnt_d == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end
endmodule

// File: rtl/atq_trig_fifo.sv
module atq_trig_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ID_W  = 4,
   parameter int unsigned OCC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop_req,
   output logic             valid,
   output logic [ID_W-1:0]  head_id,
   output logic [OCC_W-1:0] occ,
   output logic             pop_ok,
   output logic             err_empty,
   output logic             err_full
);
   localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
   localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);

   logic [OCC_W-1:0] occ_q;
   logic [ID_W-1:0]  seq_q;
   logic             acc;

   assign valid     = (occ_q != '0);
   assign occ       = occ_q;
   assign pop_ok    = pop_req && valid;
   assign err_empty = pop_req && !valid;
   assign err_full  = push && (occ_q == OCC_FULL) && !pop_ok;
   assign acc       = push && !err_full;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         occ_q <= '0;
         seq_q <= '0;
      end else begin
         if (acc && !pop_ok)
            occ_q <= occ_q + OCC_ONE;
         else if (pop_ok && !acc)
            occ_q <= occ_q - OCC_ONE;
         if (acc)
            seq_q <= seq_q + ID_W'(1);
      end
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [ID_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q <= '0;
            else if (acc && !clr)
               slot_q <= seq_q;
         end
         assign head_id = slot_q;
      end else begin : g_ring
         localparam int unsigned PTR_W = $clog2(DEPTH);
         localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

         logic [ID_W-1:0]  mem_q [DEPTH];
         logic [PTR_W-1:0] rd_q, wr_q;

         function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
            return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               rd_q <= '0;
               wr_q <= '0;
            end else begin
               if (acc)
                  wr_q <= bump(wr_q);
               if (pop_ok)
                  rd_q <= bump(rd_q);
            end
         end

         always_ff @(posedge clk) begin
            if (acc && !clr)
               mem_q[wr_q] <= seq_q;
         end

         assign head_id = valid ? mem_q[rd_q] : '0;
      end
   endgenerate
endmodule

// File: rtl/atq_decide.sv
module atq_decide #(
   parameter int unsigned OCC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pop_ok,
   input  logic [OCC_W-1:0] occ,
   input  logic             push,
   input  logic             zero_next,
   input  logic             err_any,
   output logic             done,
   output logic             notdone,
   output logic             busy,
   output logic             err
);
   import atq_pkg::*;

   dec_e dec_d, dec_q;
   logic busy_q, err_q;

   always_comb begin
      dec_d = DEC_NONE;
      if (pop_ok && !clr) begin
         if (zero_next && (occ == OCC_W'(1)) && !push)
            dec_d = DEC_DONE;
         else
            dec_d = DEC_KEEP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q  <= DEC_NONE;
         busy_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         dec_q <= dec_d;
         if (clr)
            busy_q <= 1'b1;
         else if (dec_d == DEC_DONE)
            busy_q <= 1'b0;
         if (err_any)
            err_q <= 1'b1;
      end
   end

   assign done    = (dec_q == DEC_DONE);
   assign notdone = (dec_q == DEC_KEEP);
   assign busy    = busy_q;
   assign err     = err_q;
endmodule

// File: rtl/atomic_drain_tracker.sv
module atomic_drain_tracker #(
   parameter int unsigned OUT_W = 4,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ID_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_i,
   input  logic            issue_i,
   input  logic            issue_bypass_i,
   input  logic            resp_i,
   input  logic            trig_pop_i,
   output logic            trig_valid_o,
   output logic [ID_W-1:0] trig_id_o,
   output logic            done_o,
   output logic            notdone_o,
   output logic            free_o,
   output logic            wake_o,
   output logic            busy_o,
   output logic            err_o
);
   localparam int unsigned OCC_W   = atq_pkg::occ_bits(DEPTH);
   localparam int unsigned OUT_MAX = (1 << OUT_W) - 1;

   generate
      if (OUT_W < 2) begin : g_bad_w
         $error("OUT_W must be at least 2");
      end
      if (DEPTH < OUT_MAX) begin : g_bad_depth
         $error("DEPTH must cover the maximum outstanding count");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("ID_W must be at least 1");
      end
   endgenerate

   logic             inc, dec_req, pop_req, bypass_err;
   logic             drained, zero_next, err_under, err_over;
   logic             pop_ok, err_empty, err_full, done;
   logic [OCC_W-1:0] occ;

   assign inc        = issue_i && !issue_bypass_i && !alloc_i;
   assign bypass_err = issue_i && issue_bypass_i && !alloc_i;
   assign dec_req    = resp_i && !alloc_i;
   assign pop_req    = trig_pop_i && !alloc_i;

   atq_out_counter #(.OUT_W(OUT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (alloc_i),
      .inc       (inc),
      .dec_req   (dec_req),
      .drained   (drained),
      .zero_next (zero_next),
      .err_under (err_under),
      .err_over  (err_over)
   );

   atq_trig_fifo #(.DEPTH(DEPTH), .ID_W(ID_W), .OCC_W(OCC_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (alloc_i),
      .push      (drained),
      .pop_req   (pop_req),
      .valid     (trig_valid_o),
      .head_id   (trig_id_o),
      .occ       (occ),
      .pop_ok    (pop_ok),
      .err_empty (err_empty),
      .err_full  (err_full)
   );

   atq_decide #(.OCC_W(OCC_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (alloc_i),
      .pop_ok    (pop_ok),
      .occ       (occ),
      .push      (drained),
      .zero_next (zero_next),
      .err_any   (bypass_err || err_under || err_over || err_empty || err_full),
      .done      (done),
      .notdone   (notdone_o),
      .busy      (busy_o),
      .err       (err_o)
   );

   assign done_o = done;
   assign free_o = done;
   assign wake_o = done;
endmodule

// File: rtl/atomic_drain_tracker_chk.sv
module atomic_drain_tracker_chk (
   input logic clk,
   input logic rst_n,
   input logic alloc_i,
   input logic issue_i,
   input logic issue_bypass_i,
   input logic trig_pop_i,
   input logic trig_valid_o,
   input logic done_o,
   input logic notdone_o,
   input logic free_o,
   input logic wake_o,
   input logic busy_o,
   input logic err_o
);
   p_pop_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_pop_i && trig_valid_o && !alloc_i) |=> (done_o != notdone_o));

   p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (free_o && wake_o && !busy_o));

   p_alloc_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |=> (busy_o && !trig_valid_o && !done_o && !notdone_o));

   p_bypass_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && issue_bypass_i && !alloc_i) |=> err_o);

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   p_no_result_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_pop_i || !trig_valid_o) |=> (!done_o && !notdone_o));
endmodule

bind atomic_drain_tracker atomic_drain_tracker_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .alloc_i        (alloc_i),
   .issue_i        (issue_i),
   .issue_bypass_i (issue_bypass_i),
   .trig_pop_i     (trig_pop_i),
   .trig_valid_o   (trig_valid_o),
   .done_o         (done_o),
   .notdone_o      (notdone_o),
   .free_o         (free_o),
   .wake_o         (wake_o),
   .busy_o         (busy_o),
   .err_o          (err_o)
);

// File: tb/atomic_drain_tracker_test.sv
`timescale 1ns/1ps
module atomic_drain_tracker_test;
   localparam int OUT_W = 4;
   localparam int DEPTH = 16;
   localparam int ID_W  = 4;
   localparam int MAXC  = (1 << OUT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_i = 0, issue_i = 0, issue_bypass_i = 0, resp_i = 0, trig_pop_i = 0;
   logic            trig_valid_o, done_o, notdone_o, free_o, wake_o, busy_o, err_o;
   logic [ID_W-1:0] trig_id_o;

   int checks = 0;
   int errors = 0;

   int m_out, m_seq;
   int m_q[$];
   bit m_busy, m_done, m_notdone, m_err;

   always #10 clk = ~clk;

   atomic_drain_tracker #(.OUT_W(OUT_W), .DEPTH(DEPTH), .ID_W(ID_W)) uut (
      .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .issue_i(issue_i),
      .issue_bypass_i(issue_bypass_i), .resp_i(resp_i), .trig_pop_i(trig_pop_i),
      .trig_valid_o(trig_valid_o), .trig_id_o(trig_id_o), .done_o(done_o),
      .notdone_o(notdone_o), .free_o(free_o), .wake_o(wake_o), .busy_o(busy_o),
      .err_o(err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_out = 0; m_seq = 0; m_q.delete();
      m_busy = 0; m_done = 0; m_notdone = 0; m_err = 0;
   endtask

   task automatic model_step(input bit a, input bit i, input bit b, input bit r, input bit p);
      bit inc, dec, push, popok;
      int nout, occ;
      m_done = 0; m_notdone = 0;
      if (a) begin
         m_out = 0; m_seq = 0; m_q.delete(); m_busy = 1;
         return;
      end
      inc = i && !b;
      if (i && b) m_err = 1;
      dec = r && (m_out > 0);
      if (r && m_out == 0) m_err = 1;
      if (inc && !dec && m_out == MAXC) begin
         m_err = 1;
         inc = 0;
      end
      push = dec && !(i && !b) && (m_out == 1);
      nout = m_out + int'(inc) - int'(dec);
      occ = m_q.size();
      popok = p && (occ > 0);
      if (p && occ == 0) m_err = 1;
      m_done = popok && (nout == 0) && (occ == 1) && !push;
      m_notdone = popok && !m_done;
      if (popok) void'(m_q.pop_front());
      if (push) begin
         if (occ < DEPTH || popok) begin
            m_q.push_back(m_seq);
            m_seq = (m_seq + 1) % (1 << ID_W);
         end else m_err = 1;
      end
      m_out = nout;
      if (m_done) m_busy = 0;
   endtask

   task automatic compare_all();
      chk("R3 trig_valid", int'(trig_valid_o), int'(m_q.size() > 0));
      if (m_q.size() > 0) chk("R3 trig_id", int'(trig_id_o), m_q[0]);
      chk("R4 done", int'(done_o), int'(m_done));
      chk("R4 notdone", int'(notdone_o), int'(m_notdone));
      chk("R5 free", int'(free_o), int'(m_done));
      chk("R5 wake", int'(wake_o), int'(m_done));
      chk("R6 busy", int'(busy_o), int'(m_busy));
      chk("R8 err", int'(err_o), int'(m_err));
   endtask

   task automatic cyc(input bit a, input bit i, input bit b, input bit r, input bit p);
      alloc_i = a; issue_i = i; issue_bypass_i = b; resp_i = r; trig_pop_i = p;
      model_step(a, i, b, r, p);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      alloc_i = 0; issue_i = 0; issue_bypass_i = 0; resp_i = 0; trig_pop_i = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: reset state
      chk("R1 trig_valid", int'(trig_valid_o), 0);
      chk("R1 done", int'(done_o), 0);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 err", int'(err_o), 0);

      // R2/R4/R5: three atomics drain, single trigger releases entry
      cyc(1, 0, 0, 0, 0);
      chk("R6 busy after alloc", int'(busy_o), 1);
      cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0);
      chk("R2 no trigger before zero", int'(trig_valid_o), 0);
      cyc(0, 0, 0, 1, 0);
      chk("R2 trigger after drain", int'(trig_valid_o), 1);
      chk("R2 first id", int'(trig_id_o), 0);
      cyc(0, 0, 0, 0, 1);
      chk("R4 done on sole trigger", int'(done_o), 1);
      chk("R5 busy cleared", int'(busy_o), 0);
      idle(2);

      // race: new atomic after trigger queued
      cyc(1, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0);
      cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0);
      chk("R3 second id queued behind first", int'(trig_id_o), 0);
      cyc(0, 0, 0, 0, 1);
      chk("R4 notdone with two in flight", int'(notdone_o), 1);
      chk("R3 head advances", int'(trig_id_o), 1);
      cyc(0, 0, 0, 0, 1);
      chk("R4 done on last trigger", int'(done_o), 1);

      // issue in the same cycle as a pop keeps the entry
      cyc(1, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0);
      cyc(0, 1, 0, 0, 1);
      chk("R4 same-cycle issue blocks release", int'(notdone_o), 1);
      chk("R4 busy kept", int'(busy_o), 1);
      // R9: issue and response together, no push
      cyc(0, 1, 0, 1, 0);
      chk("R9 no trigger on net-zero edge", int'(trig_valid_o), 0);
      cyc(0, 0, 0, 1, 0);
      // pop with a push on the same edge: not done
      cyc(0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 1);
      chk("R4 pop with push is notdone", int'(notdone_o), 1);
      cyc(0, 0, 0, 0, 1);
      chk("R4 final pop done", int'(done_o), 1);

      // R6: alloc clears everything and ignores same-edge inputs
      cyc(1, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0);
      cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
      cyc(1, 1, 0, 1, 1);
      chk("R6 queue emptied", int'(trig_valid_o), 0);
      chk("R6 no decision", int'(done_o) + int'(notdone_o), 0);
      cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0);
      chk("R6 id sequence restarts", int'(trig_id_o), 0);
      chk("R8 still clean", int'(err_o), 0);

      // queue fill and id wrap, then overflow push
      for (int k = 0; k < DEPTH - 1; k++) begin
         cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0);
      end
      chk("R8 full queue no error yet", int'(err_o), 0);
      cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0);
      chk("R8 push into full queue", int'(err_o), 1);
      for (int k = 0; k < DEPTH; k++) cyc(0, 0, 0, 0, 1);
      chk("R3 queue drained", int'(trig_valid_o), 0);

      // R7: bypass atomic
      do_reset();
      cyc(1, 0, 0, 0, 0);
      cyc(0, 1, 1, 0, 0);
      chk("R7 bypass flagged", int'(err_o), 1);
      cyc(0, 0, 0, 1, 0);
      chk("R7 bypass not counted", int'(trig_valid_o), 0);

      // R8: response with none outstanding
      do_reset();
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0);
      chk("R8 stray response", int'(err_o), 1);
      idle(3);
      chk("R8 sticky", int'(err_o), 1);

      // R8: pop of empty queue
      do_reset();
      cyc(0, 0, 0, 0, 1);
      chk("R8 empty pop", int'(err_o), 1);

      // R8: counter overflow
      do_reset();
      cyc(1, 0, 0, 0, 0);
      for (int k = 0; k < MAXC; k++) cyc(0, 1, 0, 0, 0);
      chk("R8 max count no error", int'(err_o), 0);
      cyc(0, 1, 0, 0, 0);
      chk("R8 overflow", int'(err_o), 1);
      for (int k = 0; k < MAXC; k++) cyc(0, 0, 0, 1, 0);
      chk("R2 drain after saturation", int'(trig_valid_o), 1);
      cyc(0, 0, 0, 0, 1);
      chk("R5 free after drain", int'(free_o), 1);
      idle(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule